// File: doc/BRIEF.md
# 4x4 Integer Inverse Transform and Reconstruction Adder

This block rebuilds one 4x4 patch of 8-bit pixels from sixteen signed 16-bit residual coefficients and a 4x4 patch of predicted pixels. In full mode it applies a multiplier-free separable integer inverse transform, first along each row and then down each column. It rounds every result with a 6-bit shift, adds it to the matching prediction pixel and saturates the sum to the 0..255 range. In DC-only mode it skips the transform, rounds coefficient 0 alone and adds that one value to all sixteen pixels.

A producer hands over a coefficient set and a prediction patch on two independent valid/ready ports. The reconstructed patch leaves on a third valid/ready port as four beats, one row of four pixels each. The coefficient store is visible on an output so that the producer can see it cleared after each use. The prediction port frees up as soon as the transform has captured the patch, so the next prediction may arrive while rows are still streaming out. A new coefficient set is taken only after the fourth row has left.

Top module: `idct4_recon`

## Requirements
- R1: Coefficient i sits at `coef_data[16*i +: 16]`, and index i = c*4 + r holds the coefficient for row r, column c (column-major order).
- R2: In full mode each 1-D pass maps inputs d0..d3 through e=d0+d2, f=d0-d2, g=(d1>>>1)-d3, h=d1+(d3>>>1) to outputs e+h, f+g, f-g, e-h. The row pass runs first and the column pass runs on its result. Every intermediate value wraps to 16 bits in two's complement.
- R3: Each transformed value x becomes (x+32)>>>6. It is added to the prediction pixel and clamped to 0..255.
- R4: Prediction pixel (r,c) sits at `pred_data[8*(4r+c) +: 8]`. The output leaves in four beats, row 0 first, and pixel c of a beat sits at `out_row[8*c +: 8]`. `out_valid` drops after the fourth beat is taken.
- R5: With `coef_dc_only` high at coefficient load, every pixel gets pred + ((coef0+32)>>>6), clamped to 0..255.
- R6: After a full-mode transform, `coef_store` reads all zero for as long as the output rows are valid.
- R7: After a DC-only operation, coefficient 0 in `coef_store` reads zero and coefficients 1..15 keep their loaded values.
- R8: `coef_ready` stays low from a coefficient acceptance until the cycle after the fourth row handshake. `pred_ready` is high during output, because the prediction is consumed when the transform is captured.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_row` stays unchanged.
- R10: After reset, `out_valid` is 0, both ready signals are 1 and `coef_store` is zero.
- R11: `out_valid` rises at the second rising edge after the later of the two load handshakes, not at the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_valid | input | 1 | Coefficient set offered |
| coef_ready | output | 1 | Coefficient store empty and accepting |
| coef_dc_only | input | 1 | Mode bit captured with the set: 1 = DC-only, 0 = full transform |
| coef_data | input | 256 | Sixteen signed 16-bit coefficients, column-major |
| pred_valid | input | 1 | Prediction patch offered |
| pred_ready | output | 1 | Prediction register free |
| pred_data | input | 128 | Sixteen 8-bit prediction pixels, row-major |
| out_valid | output | 1 | Reconstructed row available |
| out_ready | input | 1 | Consumer takes the row |
| out_row | output | 32 | Four reconstructed pixels of the current row |
| coef_store | output | 256 | Present contents of the coefficient store |

## Verification
The assertions check on every cycle the handshake invariants: rows stay unchanged under backpressure, the coefficient port stays closed while rows stream out, the store is cleared according to the captured mode, and output starts only from a fully loaded state and stops after the fourth row. The arithmetic cannot be checked that way. The column-major index order, the 16-bit wrap inside the butterflies, the rounding and the saturation at both ends are shown only by the bench scenarios. These compare every output beat with a behavioural model over directed extreme blocks and thousands of random sparse blocks under random backpressure.

// File: rtl/idct4_pkg.sv
package idct4_pkg;
    localparam int COEF_W = 16;
    localparam int PIX_W  = 8;
    localparam int DIM    = 4;
    localparam int NCOEF  = DIM * DIM;

    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_EMIT = 1'b1
    } phase_e;
endpackage

// File: rtl/idct4_bfly.sv
module idct4_bfly #(
    parameter int W = idct4_pkg::COEF_W
) (
    input  logic [4*W-1:0] in_vec,
    output logic [4*W-1:0] out_vec
);
    logic signed [W-1:0] d0, d1, d2, d3;
    logic signed [W-1:0] sum_ev, dif_ev, odd_a, odd_b;

    assign d0 = in_vec[0*W +: W];
    assign d1 = in_vec[1*W +: W];
    assign d2 = in_vec[2*W +: W];
    assign d3 = in_vec[3*W +: W];

    // shift/add only; all sums wrap at W bits
    assign sum_ev = d0 + d2;
    assign dif_ev = d0 - d2;
    assign odd_a  = (d1 >>> 1) - d3;
    assign odd_b  = d1 + (d3 >>> 1);

    assign out_vec[0*W +: W] = sum_ev + odd_b;
    assign out_vec[1*W +: W] = dif_ev + odd_a;
    assign out_vec[2*W +: W] = dif_ev - odd_a;
    assign out_vec[3*W +: W] = sum_ev - odd_b;
endmodule

// File: rtl/idct4_xform.sv
module idct4_xform #(
    parameter int W   = idct4_pkg::COEF_W,
    parameter int DIM = idct4_pkg::DIM
) (
    input  logic [DIM*DIM*W-1:0] coef_cm,
    output logic [DIM*DIM*W-1:0] res_rm
);
    localparam int LANE = DIM * W;

    logic [DIM*DIM*W-1:0] mid_rm;
    logic [LANE-1:0]      row_in  [DIM];
    logic [LANE-1:0]      col_in  [DIM];
    logic [LANE-1:0]      col_out [DIM];

    for (genvar r = 0; r < DIM; r++) begin : g_row
        for (genvar k = 0; k < DIM; k++) begin : g_gather
            // column-major source: column k, row r
            assign row_in[r][k*W +: W] = coef_cm[(k*DIM + r)*W +: W];
        end
        idct4_bfly #(.W(W)) u_row (
            .in_vec (row_in[r]),
            .out_vec(mid_rm[r*LANE +: LANE])
        );
    end

    for (genvar c = 0; c < DIM; c++) begin : g_col
        for (genvar k = 0; k < DIM; k++) begin : g_gather
            assign col_in[c][k*W +: W]          = mid_rm[(k*DIM + c)*W +: W];
            assign res_rm[(k*DIM + c)*W +: W]   = col_out[c][k*W +: W];
        end
        idct4_bfly #(.W(W)) u_col (
            .in_vec (col_in[c]),
            .out_vec(col_out[c])
        );
    end
endmodule

// File: rtl/idct4_add.sv
module idct4_add #(
    parameter int W   = idct4_pkg::COEF_W,
    parameter int PW  = idct4_pkg::PIX_W,
    parameter int NPX = idct4_pkg::NCOEF
) (
    input  logic [NPX*W-1:0]  res_rm,
    input  logic [NPX*PW-1:0] pred_rm,
    input  logic              dc_only,
    input  logic [W-1:0]      dc_coef,
    output logic [NPX*PW-1:0] pix_rm
);
    localparam int RND_SH = 6;
    localparam int PIX_MAX = (1 << PW) - 1;

    for (genvar i = 0; i < NPX; i++) begin : g_px
        logic signed [W-1:0]   pre_v;
        logic signed [W:0]     pre_x, sum_x, rnd_x;
        logic signed [W+1:0]   tot_x;
        logic [PW-1:0]         px_o;

        assign pre_v = dc_only ? $signed(dc_coef) : $signed(res_rm[i*W +: W]);
        assign pre_x = {pre_v[W-1], pre_v};
        assign sum_x = pre_x + $signed((W+1)'(32));
        assign rnd_x = sum_x >>> RND_SH;
        assign tot_x = {rnd_x[W], rnd_x}
                     + $signed({2'b00, {(W-PW){1'b0}}, pred_rm[i*PW +: PW]});

        always_comb begin
            if (tot_x < 0) begin
                px_o = '0;
            end else if (tot_x > $signed((W+2)'(PIX_MAX))) begin
                px_o = PW'(PIX_MAX);
            end else begin
                px_o = tot_x[PW-1:0];
            end
        end
        assign pix_rm[i*PW +: PW] = px_o;
    end
endmodule

// File: rtl/idct4_recon.sv
module idct4_recon
    import idct4_pkg::*;
#(
    parameter int W  = COEF_W,
    parameter int PW = PIX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  coef_valid,
    output logic                  coef_ready,
    input  logic                  coef_dc_only,
    input  logic [NCOEF*W-1:0]    coef_data,
    input  logic                  pred_valid,
    output logic                  pred_ready,
    input  logic [NCOEF*PW-1:0]   pred_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [DIM*PW-1:0]     out_row,
    output logic [NCOEF*W-1:0]    coef_store
);
    localparam int ROW_W   = $clog2(DIM);
    localparam int ROW_PIX = DIM * PW;
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(DIM - 1);

    typedef struct packed {
        phase_e                 phase;
        logic                   coef_have;
        logic                   pred_have;
        logic                   dc;
        logic [ROW_W-1:0]       row;
        logic [NCOEF*W-1:0]     coef;
        logic [NCOEF*PW-1:0]    pred;
        logic [NCOEF*PW-1:0]    pix;
    } state_t;

    state_t q, d;

    logic [NCOEF*W-1:0]  res_w;
    logic [NCOEF*PW-1:0] pix_w;

    idct4_xform #(.W(W), .DIM(DIM)) u_xform (
        .coef_cm(q.coef),
        .res_rm (res_w)
    );

    idct4_add #(.W(W), .PW(PW), .NPX(NCOEF)) u_add (
        .res_rm (res_w),
        .pred_rm(q.pred),
        .dc_only(q.dc),
        .dc_coef(q.coef[W-1:0]),
        .pix_rm (pix_w)
    );

    always_comb begin
        d          = q;
        coef_ready = !q.coef_have;
        pred_ready = !q.pred_have;
        if (coef_valid && coef_ready) begin
            d.coef_have = 1'b1;
            d.coef      = coef_data;
            d.dc        = coef_dc_only;
        end
        if (pred_valid && pred_ready) begin
            d.pred_have = 1'b1;
            d.pred      = pred_data;
        end
        case (q.phase)
            ST_LOAD: begin
                if (q.coef_have && q.pred_have) begin
                    d.phase     = ST_EMIT;
                    d.pix       = pix_w;
                    d.pred_have = 1'b0;
                    d.row       = '0;
                    if (q.dc) begin
                        d.coef[W-1:0] = '0;
                    end else begin
                        d.coef = '0;
                    end
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    d.row = q.row + 1'b1;
                    if (q.row == LAST_ROW) begin
                        d.phase     = ST_LOAD;
                        d.coef_have = 1'b0;
                    end
                end
            end
            default: d.phase = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid  = (q.phase == ST_EMIT);
    assign out_row    = q.pix[q.row*ROW_PIX +: ROW_PIX];
    assign coef_store = q.coef;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_row));

    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !coef_ready);

    assert_clear_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !q.dc |-> coef_store == '0);

    assert_clear_dc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && q.dc |-> coef_store[W-1:0] == '0);

    assert_last_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && q.row == LAST_ROW |=> !out_valid);

    assert_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(q.coef_have && q.pred_have));
endmodule

// File: tb/idct4_recon_tb.sv
module idct4_recon_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         coef_valid = 1'b0;
    logic         coef_ready;
    logic         coef_dc_only = 1'b0;
    logic [255:0] coef_data = '0;
    logic         pred_valid = 1'b0;
    logic         pred_ready;
    logic [127:0] pred_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [31:0]  out_row;
    logic [255:0] coef_store;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    idct4_recon dut_i (
        .clk(clk), .rst_n(rst_n),
        .coef_valid(coef_valid), .coef_ready(coef_ready),
        .coef_dc_only(coef_dc_only), .coef_data(coef_data),
        .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_data(pred_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
        .coef_store(coef_store)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int w16(input int x);
        shortint s;
        s = shortint'(x);
        return int'(s);
    endfunction

    function automatic int clamp8(input int x);
        return (x < 0) ? 0 : ((x > 255) ? 255 : x);
    endfunction

    // behavioural reconstruction: exp[r*4+c]
    task automatic model(input int cf[16], input bit dc, input logic [127:0] pr, output int ex[16]);
        int tmp[16];
        int outv[16];
        int a[4];
        int e, f, g, h;
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 4; k++) a[k] = cf[k*4 + r];
            e = w16(a[0] + a[2]); f = w16(a[0] - a[2]);
            g = w16((a[1] >>> 1) - a[3]); h = w16(a[1] + (a[3] >>> 1));
            tmp[r*4+0] = w16(e + h); tmp[r*4+1] = w16(f + g);
            tmp[r*4+2] = w16(f - g); tmp[r*4+3] = w16(e - h);
        end
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 4; k++) a[k] = tmp[k*4 + c];
            e = w16(a[0] + a[2]); f = w16(a[0] - a[2]);
            g = w16((a[1] >>> 1) - a[3]); h = w16(a[1] + (a[3] >>> 1));
            outv[0*4+c] = w16(e + h); outv[1*4+c] = w16(f + g);
            outv[2*4+c] = w16(f - g); outv[3*4+c] = w16(e - h);
        end
        for (int i = 0; i < 16; i++) begin
            int v;
            v = dc ? cf[0] : outv[i];
            ex[i] = clamp8(int'(pr[8*i +: 8]) + ((v + 32) >>> 6));
        end
    endtask

    task automatic run_block(input int cf[16], input bit dc, input logic [127:0] pr,
                             input string tag, input bit stall);
        int ex[16];
        logic [255:0] exp_store;
        bit c_acc, p_acc;
        logic [31:0] held;
        model(cf, dc, pr, ex);
        exp_store = '0;
        for (int i = 0; i < 16; i++) exp_store[16*i +: 16] = cf[i][15:0];
        if (dc) exp_store[15:0] = '0; else exp_store = '0;
        @(negedge clk);
        check(coef_ready == 1'b1, "R8 coef_ready idle", coef_ready, 1);
        coef_valid = 1'b1; coef_dc_only = dc;
        for (int i = 0; i < 16; i++) coef_data[16*i +: 16] = cf[i][15:0];
        pred_valid = 1'b1; pred_data = pr;
        forever begin
            c_acc = coef_valid && coef_ready;
            p_acc = pred_valid && pred_ready;
            @(negedge clk);
            if (c_acc) coef_valid = 1'b0;
            if (p_acc) pred_valid = 1'b0;
            if (!coef_valid && !pred_valid) break;
        end
        check(out_valid == 1'b0, "R11 no output one edge after load", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R11 output two edges after load", out_valid, 1);
        check(coef_store == exp_store, dc ? "R7 DC store clear" : "R6 full store clear",
              longint'(coef_store[63:0]), longint'(exp_store[63:0]));
        for (int r = 0; r < 4; r++) begin
            logic [31:0] exp_row;
            for (int c = 0; c < 4; c++) exp_row[8*c +: 8] = ex[r*4+c][7:0];
            forever begin
                bit rdy;
                rdy = stall ? (($urandom % 4) != 0) : 1'b1;
                out_ready = rdy;
                check(out_valid && !coef_ready && pred_ready, "R8 ports during output",
                      {out_valid, coef_ready, pred_ready}, 3'b101);
                if (rdy) break;
                held = out_row;
                @(negedge clk);
                check(out_valid && out_row == held, "R9 stall hold", out_row, held);
            end
            check(out_row == exp_row, tag, out_row, exp_row);
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(!out_valid && coef_ready, "R4 R8 end of patch", {out_valid, coef_ready}, 2'b01);
    endtask

    function automatic logic [127:0] rand_pred();
        logic [127:0] p;
        for (int i = 0; i < 4; i++) p[32*i +: 32] = $urandom;
        return p;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cf[16];
        logic [127:0] pr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && coef_ready && pred_ready && coef_store == '0, "R10 reset state",
              {out_valid, coef_ready, pred_ready}, 3'b011);
        rst_n = 1'b1;

        // R1: single coefficient at index 1 = row 1, column 0
        foreach (cf[i]) cf[i] = 0;
        cf[1] = 400;
        run_block(cf, 1'b0, {16{8'd128}}, "R1 column-major order", 1'b0);
        foreach (cf[i]) cf[i] = 0;
        cf[4] = -300; cf[14] = 257;
        run_block(cf, 1'b0, {16{8'd100}}, "R1 R2 two coefficients", 1'b0);

        // R2: 16-bit wrap in the butterflies
        foreach (cf[i]) cf[i] = 32767;
        run_block(cf, 1'b0, rand_pred(), "R2 wrap all max", 1'b0);
        foreach (cf[i]) cf[i] = (i % 2) ? -32768 : 32767;
        run_block(cf, 1'b0, rand_pred(), "R2 wrap alternating", 1'b0);

        // R3: rounding edge and both saturation ends
        foreach (cf[i]) cf[i] = 0;
        cf[0] = 32;
        run_block(cf, 1'b0, {16{8'd255}}, "R3 round up and clamp high", 1'b0);
        cf[0] = -33;
        run_block(cf, 1'b0, {16{8'd0}}, "R3 round down and clamp low", 1'b0);

        // R5 / R7: DC-only mode, remaining coefficients kept
        foreach (cf[i]) cf[i] = 1000 + i;
        cf[0] = 32767;
        run_block(cf, 1'b1, rand_pred(), "R5 DC saturate high", 1'b0);
        cf[0] = -32768;
        run_block(cf, 1'b1, rand_pred(), "R5 DC saturate low", 1'b0);
        cf[0] = 95;
        run_block(cf, 1'b1, rand_pred(), "R5 DC mid", 1'b1);

        // random sparse blocks with backpressure
        for (int n = 0; n < 10000; n++) begin
            bit dc;
            int nz;
            foreach (cf[i]) cf[i] = 0;
            nz = $urandom_range(1, 8);
            for (int k = 0; k < nz; k++)
                cf[$urandom_range(0, 15)] = int'($urandom_range(0, 1023)) - 512;
            dc = ($urandom % 8) == 0;
            pr = rand_pred();
            run_block(cf, dc, pr, dc ? "R5 random DC block" : "R2 R3 R4 random block", 1'b1);
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule